// File: doc/BRIEF.md
# Hardware Thread Fork Allocator

This block serves the fork operation of a multithreaded processor core. It keeps one status record per hardware thread context. A fork request names the requesting context, a start address, an operand value and a destination register index. The allocator then walks its context table from index 0 upward and picks the first context that is free in the requester's virtual processor. It loads that context's restart address, sends the operand value out on a one-cycle register-file write port, and brings the context's status up in the running state. The new context takes its privilege mode and address-space id from the requester.

When no context qualifies, the allocator records exception code 1 and pulses a thread-fault output together with its completion strobe. The walk costs one cycle per context visited. While a walk is in progress, new fork requests and table configuration writes are dropped. A configuration write port sets the binding, allocatable, halt, activated, delay-slot, mode and address-space fields of one context. A read port shows any context's full record and restart address. The number of contexts is one more than the `MAX_CTX_SEL` parameter.

Top module: `fork_alloc`

## Requirements
- R1: After reset every context reads virtual processor 0, allocatable 1, halted 0, activated 0, dirty 0, delay-slot 0, run state 1, mode 0, address-space id 0 and restart address 0. `fork_done`, `thread_fault` and `rf_we` are low, and `exc_code` is 0.
- R2: A request accepted at clock edge E walks the contexts in ascending index order and picks the lowest index that qualifies. When it picks index k, `fork_done` is high for exactly one cycle, after edge E+k+1, with `fork_ok`=1 and `fork_ctx`=k.
- R3: A context qualifies only when all four of these hold: its virtual processor field equals the requester's, its allocatable bit is 1, its halt bit is 0 and its activated bit is 0.
- R4: On success the chosen context's restart address becomes `fork_pc`. In the same cycle as `fork_done`, `rf_we` pulses with `rf_ctx`=chosen index, `rf_idx`=`fork_dst` and `rf_data`=`fork_val`. `rf_we` is never high at any other time.
- R5: On success the chosen context's run state becomes 0, its delay-slot flag becomes 0, its dirty flag becomes 1 and its activated bit becomes 1.
- R6: On success the chosen context's mode and address-space id become those the requester held when its request was accepted.
- R7: When no context qualifies, `fork_done` rises after edge E+NUM_CTX with `fork_ok`=0 and `exc_code`=1. `thread_fault` is high in that same cycle only, and no context record changes.
- R8: A successful fork sets `exc_code` back to 0.
- R9: While a walk is in progress, `fork_req` and `cfg_we` are ignored. They start no second walk, produce no further `fork_done` and change no context record.
- R10: When no walk is in progress, `cfg_we` writes the binding, allocatable, halt, activated, delay-slot, mode and address-space id of context `cfg_ctx` at the next edge. It leaves the dirty flag, run state and restart address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fork_req | input | 1 | Fork request, sampled when idle |
| fork_src | input | 3 | Index of the requesting context |
| fork_pc | input | 32 | Start address for the new context |
| fork_val | input | 32 | Value for the new context's destination register |
| fork_dst | input | 5 | Destination register index |
| fork_done | output | 1 | One-cycle completion strobe |
| fork_ok | output | 1 | Result of the last fork (1 = context found) |
| fork_ctx | output | 3 | Context chosen by the last successful fork |
| exc_code | output | 3 | Exception code (1 = no free context, 0 = none) |
| thread_fault | output | 1 | One-cycle fault pulse on a failed fork |
| rf_we | output | 1 | Register-file write strobe |
| rf_ctx | output | 3 | Context of the register write |
| rf_idx | output | 5 | Register index of the write |
| rf_data | output | 32 | Register write value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctx | input | 3 | Context to configure |
| cfg_vpe | input | 2 | Virtual processor binding |
| cfg_alloc | input | 1 | Allocatable bit |
| cfg_halt | input | 1 | Halt bit |
| cfg_active | input | 1 | Activated bit |
| cfg_dslot | input | 1 | Delay-slot flag |
| cfg_mode | input | 2 | Kernel/user mode field |
| cfg_asid | input | 8 | Address-space id |
| rd_ctx | input | 3 | Context to observe |
| rd_vpe | output | 2 | Observed binding |
| rd_alloc | output | 1 | Observed allocatable bit |
| rd_halt | output | 1 | Observed halt bit |
| rd_active | output | 1 | Observed activated bit |
| rd_dirty | output | 1 | Observed dirty flag |
| rd_dslot | output | 1 | Observed delay-slot flag |
| rd_runst | output | 2 | Observed run state |
| rd_mode | output | 2 | Observed mode |
| rd_asid | output | 8 | Observed address-space id |
| rd_pc | output | 32 | Observed restart address |

## Verification
The bench excludes contexts one condition at a time: one halted, one not allocatable, one bound elsewhere, and one activated. A qualification test that dropped any one of these terms would therefore pick a lower index than expected. Both the last context and a full failure are reached, so a walk that stopped one index early, or that faulted on the last hit, shows a wrong latency or result. A second virtual processor confirms that the requester's own binding, mode and address-space id are used. A request and a configuration write arrive in the middle of a long walk: a design that accepted either would emit an extra completion or alter a halt bit.

// File: rtl/fork_alloc_pkg.sv
package fork_alloc_pkg;

    localparam int VPE_W   = 2;
    localparam int ASID_W  = 8;
    localparam int MODE_W  = 2;
    localparam int RUNST_W = 2;
    localparam int EXC_W   = 3;

    localparam logic [RUNST_W-1:0] RUNST_RUNNING = 2'd0;
    localparam logic [RUNST_W-1:0] RUNST_PARKED  = 2'd1;

    localparam logic [EXC_W-1:0] EXC_NONE    = 3'd0;
    localparam logic [EXC_W-1:0] EXC_NO_FREE = 3'd1;

    typedef struct packed {
        logic [VPE_W-1:0]   vpe;
        logic               alloc;
        logic               halt;
        logic               active;
        logic               dirty;
        logic               dslot;
        logic [RUNST_W-1:0] runst;
        logic [MODE_W-1:0]  mode;
        logic [ASID_W-1:0]  asid;
    } ctx_stat_t;

    typedef enum logic [0:0] {
        SC_IDLE = 1'b0,
        SC_SCAN = 1'b1
    } scan_st_e;

    function automatic ctx_stat_t reset_stat();
        ctx_stat_t r;
        r.vpe    = '0;
        r.alloc  = 1'b1;
        r.halt   = 1'b0;
        r.active = 1'b0;
        r.dirty  = 1'b0;
        r.dslot  = 1'b0;
        r.runst  = RUNST_PARKED;
        r.mode   = '0;
        r.asid   = '0;
        return r;
    endfunction

    function automatic logic is_free(ctx_stat_t s, logic [VPE_W-1:0] want_vpe);
        return (s.vpe == want_vpe) && s.alloc && !s.halt && !s.active;
    endfunction

    function automatic ctx_stat_t spawn_stat(ctx_stat_t old,
                                             logic [MODE_W-1:0] m,
                                             logic [ASID_W-1:0] a);
        ctx_stat_t r;
        r        = old;
        r.runst  = RUNST_RUNNING;
        r.dslot  = 1'b0;
        r.dirty  = 1'b1;
        r.active = 1'b1;
        r.mode   = m;
        r.asid   = a;
        return r;
    endfunction

    function automatic ctx_stat_t merge_cfg(ctx_stat_t old, ctx_stat_t upd);
        ctx_stat_t r;
        r       = upd;
        r.dirty = old.dirty;
        r.runst = old.runst;
        return r;
    endfunction

endpackage

// File: rtl/ctx_table.sv
module ctx_table
    import fork_alloc_pkg::*;
#(
    parameter int NUM_CTX = 8,
    parameter int IDX_W   = 3,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  ctx_stat_t         cfg_stat,
    input  logic              commit_en,
    input  logic [IDX_W-1:0]  commit_idx,
    input  ctx_stat_t         commit_stat,
    input  logic [ADDR_W-1:0] commit_pc,
    input  logic [IDX_W-1:0]  probe_idx,
    output ctx_stat_t         probe_stat,
    input  logic [IDX_W-1:0]  src_idx,
    output ctx_stat_t         src_stat,
    input  logic [IDX_W-1:0]  rd_idx,
    output ctx_stat_t         rd_stat,
    output logic [ADDR_W-1:0] rd_pc
);

    ctx_stat_t         stat_arr [NUM_CTX];
    logic [ADDR_W-1:0] pc_arr   [NUM_CTX];

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_entry
        ctx_stat_t         s_q;
        logic [ADDR_W-1:0] pc_q;
        logic              hit_commit;
        logic              hit_cfg;

        assign hit_commit = commit_en && (commit_idx == IDX_W'(g));
        assign hit_cfg    = cfg_en && (cfg_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                s_q  <= reset_stat();
                pc_q <= '0;
            end else if (hit_commit) begin
                s_q  <= commit_stat;
                pc_q <= commit_pc;
            end else if (hit_cfg) begin
                s_q  <= merge_cfg(s_q, cfg_stat);
            end
        end

        assign stat_arr[g] = s_q;
        assign pc_arr[g]   = pc_q;
    end

    assign probe_stat = stat_arr[probe_idx];
    assign src_stat   = stat_arr[src_idx];
    assign rd_stat    = stat_arr[rd_idx];
    assign rd_pc      = pc_arr[rd_idx];

    AST_COMMIT_MARKS_LIVE: assert property (@(posedge clk) disable iff (rst)
        commit_en |=> (stat_arr[$past(commit_idx)].active && stat_arr[$past(commit_idx)].dirty))
        else $error("commit did not mark context live"); // R5

    AST_CFG_NOT_WITH_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !(cfg_en && commit_en))
        else $error("config write during a walk"); // R9

endmodule

// File: rtl/fork_scanner.sv
module fork_scanner
    import fork_alloc_pkg::*;
#(
    parameter int NUM_CTX = 8,
    parameter int IDX_W   = 3,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int RIDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_pc,
    input  logic [DATA_W-1:0] req_val,
    input  logic [RIDX_W-1:0] req_dst,
    input  ctx_stat_t         src_stat,
    output logic [IDX_W-1:0]  probe_idx,
    input  ctx_stat_t         probe_stat,
    output logic              busy,
    output logic              commit_en,
    output logic [IDX_W-1:0]  commit_idx,
    output ctx_stat_t         commit_stat,
    output logic [ADDR_W-1:0] commit_pc,
    output logic              done,
    output logic              ok,
    output logic [IDX_W-1:0]  ctx,
    output logic [EXC_W-1:0]  exc,
    output logic              fault,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_ctx,
    output logic [RIDX_W-1:0] wr_reg,
    output logic [DATA_W-1:0] wr_data
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CTX - 1);

    typedef struct packed {
        logic [VPE_W-1:0]  vpe;
        logic [MODE_W-1:0] mode;
        logic [ASID_W-1:0] asid;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] val;
        logic [RIDX_W-1:0] dst;
    } job_t;

    scan_st_e         st_q;
    job_t             job_q;
    logic [IDX_W-1:0] scan_q;
    logic             hit;
    logic             at_last;

    assign busy      = (st_q == SC_SCAN);
    assign probe_idx = scan_q;
    assign hit       = busy && is_free(probe_stat, job_q.vpe);
    assign at_last   = (scan_q == LAST_IDX);

    assign commit_en   = hit;
    assign commit_idx  = scan_q;
    assign commit_stat = spawn_stat(probe_stat, job_q.mode, job_q.asid);
    assign commit_pc   = job_q.pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SC_IDLE;
            job_q   <= '0;
            scan_q  <= '0;
            done    <= 1'b0;
            ok      <= 1'b0;
            ctx     <= '0;
            exc     <= EXC_NONE;
            fault   <= 1'b0;
            wr_en   <= 1'b0;
            wr_ctx  <= '0;
            wr_reg  <= '0;
            wr_data <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            wr_en <= 1'b0;
            unique case (st_q)
                SC_IDLE: begin
                    if (req) begin
                        st_q       <= SC_SCAN;
                        scan_q     <= '0;
                        job_q.vpe  <= src_stat.vpe;
                        job_q.mode <= src_stat.mode;
                        job_q.asid <= src_stat.asid;
                        job_q.pc   <= req_pc;
                        job_q.val  <= req_val;
                        job_q.dst  <= req_dst;
                    end
                end
                SC_SCAN: begin
                    if (hit) begin
                        st_q    <= SC_IDLE;
                        done    <= 1'b1;
                        ok      <= 1'b1;
                        ctx     <= scan_q;
                        exc     <= EXC_NONE;
                        wr_en   <= 1'b1;
                        wr_ctx  <= scan_q;
                        wr_reg  <= job_q.dst;
                        wr_data <= job_q.val;
                    end else if (at_last) begin
                        st_q  <= SC_IDLE;
                        done  <= 1'b1;
                        ok    <= 1'b0;
                        exc   <= EXC_NO_FREE;
                        fault <= 1'b1;
                    end else begin
                        scan_q <= scan_q + 1'b1;
                    end
                end
                default: st_q <= SC_IDLE;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("done held for more than one cycle"); // R2

    AST_SCAN_ASCENDS: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(rst)) |-> (scan_q == $past(scan_q) + 1'b1))
        else $error("walk skipped or repeated an index"); // R2

    AST_FAULT_ON_FAIL_ONLY: assert property (@(posedge clk) disable iff (rst)
        fault |-> (done && !ok && exc == EXC_NO_FREE))
        else $error("fault without failed completion"); // R7

    AST_FAIL_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (done && !ok) |-> ($past(scan_q) == LAST_IDX))
        else $error("failure before the last context"); // R7

    AST_WRITE_WITH_SUCCESS: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (done && ok))
        else $error("register write outside a successful fork"); // R4

endmodule

// File: rtl/fork_alloc.sv
module fork_alloc
    import fork_alloc_pkg::*;
#(
    parameter int MAX_CTX_SEL = 7,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int RIDX_W      = 5,
    localparam int NUM_CTX    = MAX_CTX_SEL + 1,
    localparam int IDX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fork_req,
    input  logic [IDX_W-1:0]   fork_src,
    input  logic [ADDR_W-1:0]  fork_pc,
    input  logic [DATA_W-1:0]  fork_val,
    input  logic [RIDX_W-1:0]  fork_dst,
    output logic               fork_done,
    output logic               fork_ok,
    output logic [IDX_W-1:0]   fork_ctx,
    output logic [EXC_W-1:0]   exc_code,
    output logic               thread_fault,
    output logic               rf_we,
    output logic [IDX_W-1:0]   rf_ctx,
    output logic [RIDX_W-1:0]  rf_idx,
    output logic [DATA_W-1:0]  rf_data,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_ctx,
    input  logic [VPE_W-1:0]   cfg_vpe,
    input  logic               cfg_alloc,
    input  logic               cfg_halt,
    input  logic               cfg_active,
    input  logic               cfg_dslot,
    input  logic [MODE_W-1:0]  cfg_mode,
    input  logic [ASID_W-1:0]  cfg_asid,
    input  logic [IDX_W-1:0]   rd_ctx,
    output logic [VPE_W-1:0]   rd_vpe,
    output logic               rd_alloc,
    output logic               rd_halt,
    output logic               rd_active,
    output logic               rd_dirty,
    output logic               rd_dslot,
    output logic [RUNST_W-1:0] rd_runst,
    output logic [MODE_W-1:0]  rd_mode,
    output logic [ASID_W-1:0]  rd_asid,
    output logic [ADDR_W-1:0]  rd_pc
);

    logic              busy;
    logic              cfg_en;
    ctx_stat_t         cfg_stat;
    logic [IDX_W-1:0]  probe_idx;
    ctx_stat_t         probe_stat;
    ctx_stat_t         src_stat;
    ctx_stat_t         rd_stat;
    logic              commit_en;
    logic [IDX_W-1:0]  commit_idx;
    ctx_stat_t         commit_stat;
    logic [ADDR_W-1:0] commit_pc;

    assign cfg_en = cfg_we && !busy;

    always_comb begin
        cfg_stat        = '0;
        cfg_stat.vpe    = cfg_vpe;
        cfg_stat.alloc  = cfg_alloc;
        cfg_stat.halt   = cfg_halt;
        cfg_stat.active = cfg_active;
        cfg_stat.dslot  = cfg_dslot;
        cfg_stat.mode   = cfg_mode;
        cfg_stat.asid   = cfg_asid;
    end

    ctx_table #(
        .NUM_CTX (NUM_CTX),
        .IDX_W   (IDX_W),
        .ADDR_W  (ADDR_W)
    ) table_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_en      (cfg_en),
        .cfg_idx     (cfg_ctx),
        .cfg_stat    (cfg_stat),
        .commit_en   (commit_en),
        .commit_idx  (commit_idx),
        .commit_stat (commit_stat),
        .commit_pc   (commit_pc),
        .probe_idx   (probe_idx),
        .probe_stat  (probe_stat),
        .src_idx     (fork_src),
        .src_stat    (src_stat),
        .rd_idx      (rd_ctx),
        .rd_stat     (rd_stat),
        .rd_pc       (rd_pc)
    );

    fork_scanner #(
        .NUM_CTX (NUM_CTX),
        .IDX_W   (IDX_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .RIDX_W  (RIDX_W)
    ) scan_i (
        .clk         (clk),
        .rst         (rst),
        .req         (fork_req),
        .req_pc      (fork_pc),
        .req_val     (fork_val),
        .req_dst     (fork_dst),
        .src_stat    (src_stat),
        .probe_idx   (probe_idx),
        .probe_stat  (probe_stat),
        .busy        (busy),
        .commit_en   (commit_en),
        .commit_idx  (commit_idx),
        .commit_stat (commit_stat),
        .commit_pc   (commit_pc),
        .done        (fork_done),
        .ok          (fork_ok),
        .ctx         (fork_ctx),
        .exc         (exc_code),
        .fault       (thread_fault),
        .wr_en       (rf_we),
        .wr_ctx      (rf_ctx),
        .wr_reg      (rf_idx),
        .wr_data     (rf_data)
    );

    assign rd_vpe    = rd_stat.vpe;
    assign rd_alloc  = rd_stat.alloc;
    assign rd_halt   = rd_stat.halt;
    assign rd_active = rd_stat.active;
    assign rd_dirty  = rd_stat.dirty;
    assign rd_dslot  = rd_stat.dslot;
    assign rd_runst  = rd_stat.runst;
    assign rd_mode   = rd_stat.mode;
    assign rd_asid   = rd_stat.asid;

    AST_NO_WRITE_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
        thread_fault |-> !rf_we)
        else $error("register write on a failed fork"); // R7

endmodule

// File: tb/fork_alloc_tb_top.sv
module fork_alloc_tb_top;

    localparam int N  = 8;
    localparam int IW = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fork_req = 1'b0;
    logic [2:0]  fork_src = '0;
    logic [31:0] fork_pc = '0;
    logic [31:0] fork_val = '0;
    logic [4:0]  fork_dst = '0;
    logic        fork_done, fork_ok, thread_fault, rf_we;
    logic [2:0]  fork_ctx, exc_code, rf_ctx;
    logic [4:0]  rf_idx;
    logic [31:0] rf_data;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_ctx = '0;
    logic [1:0]  cfg_vpe = '0;
    logic        cfg_alloc = 1'b0, cfg_halt = 1'b0, cfg_active = 1'b0, cfg_dslot = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic [7:0]  cfg_asid = '0;
    logic [2:0]  rd_ctx = '0;
    logic [1:0]  rd_vpe, rd_runst, rd_mode;
    logic        rd_alloc, rd_halt, rd_active, rd_dirty, rd_dslot;
    logic [7:0]  rd_asid;
    logic [31:0] rd_pc;

    always #10 clk = ~clk;

    fork_alloc dut_i (
        .clk(clk), .rst(rst),
        .fork_req(fork_req), .fork_src(fork_src), .fork_pc(fork_pc),
        .fork_val(fork_val), .fork_dst(fork_dst),
        .fork_done(fork_done), .fork_ok(fork_ok), .fork_ctx(fork_ctx),
        .exc_code(exc_code), .thread_fault(thread_fault),
        .rf_we(rf_we), .rf_ctx(rf_ctx), .rf_idx(rf_idx), .rf_data(rf_data),
        .cfg_we(cfg_we), .cfg_ctx(cfg_ctx), .cfg_vpe(cfg_vpe), .cfg_alloc(cfg_alloc),
        .cfg_halt(cfg_halt), .cfg_active(cfg_active), .cfg_dslot(cfg_dslot),
        .cfg_mode(cfg_mode), .cfg_asid(cfg_asid),
        .rd_ctx(rd_ctx), .rd_vpe(rd_vpe), .rd_alloc(rd_alloc), .rd_halt(rd_halt),
        .rd_active(rd_active), .rd_dirty(rd_dirty), .rd_dslot(rd_dslot),
        .rd_runst(rd_runst), .rd_mode(rd_mode), .rd_asid(rd_asid), .rd_pc(rd_pc)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit good, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!good) begin
            n_err++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // bench model of the context table
    logic [1:0]  m_vpe   [N];
    logic        m_alloc [N];
    logic        m_halt  [N];
    logic        m_act   [N];
    logic        m_dirty [N];
    logic        m_ds    [N];
    logic [1:0]  m_run   [N];
    logic [1:0]  m_mode  [N];
    logic [7:0]  m_asid  [N];
    logic [31:0] m_pc    [N];

    typedef struct {
        bit          ok;
        int          ctx;
        int          exc;
        int          due;
        logic [31:0] val;
        logic [4:0]  dst;
    } exp_t;
    exp_t sb_q[$];

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (fork_done) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R9", "completion with nothing outstanding", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(cyc == e.due, "R2", "completion cycle", cyc, e.due);
                    chk(fork_ok == e.ok, "R2", "success flag", fork_ok, e.ok);
                    chk(exc_code == 3'(e.exc), e.ok ? "R8" : "R7", "exception code", exc_code, e.exc);
                    chk(thread_fault == !e.ok, "R7", "fault pulse", thread_fault, !e.ok);
                    chk(rf_we == e.ok, "R4", "register write strobe", rf_we, e.ok);
                    if (e.ok) begin
                        chk(fork_ctx == 3'(e.ctx), "R3", "chosen context", fork_ctx, e.ctx);
                        chk(rf_ctx == 3'(e.ctx), "R4", "write context", rf_ctx, e.ctx);
                        chk(rf_idx == e.dst, "R4", "write index", rf_idx, e.dst);
                        chk(rf_data == e.val, "R4", "write data", rf_data, e.val);
                    end
                end
            end else begin
                if (thread_fault) chk(1'b0, "R7", "fault without completion", 1, 0);
                if (rf_we) chk(1'b0, "R4", "write without completion", 1, 0);
            end
        end
    end

    task automatic check_ctx(input int i, input string tag);
        logic [23:0] act, exp;
        rd_ctx = 3'(i);
        #1;
        act = {rd_vpe, rd_alloc, rd_halt, rd_active, rd_dirty, rd_dslot, rd_runst, rd_mode, rd_asid, 5'(i)};
        exp = {m_vpe[i], m_alloc[i], m_halt[i], m_act[i], m_dirty[i], m_ds[i], m_run[i], m_mode[i], m_asid[i], 5'(i)};
        chk(act == exp, tag, $sformatf("status of context %0d", i), act, exp);
        chk(rd_pc == m_pc[i], tag, $sformatf("restart of context %0d", i), rd_pc, m_pc[i]);
    endtask

    task automatic cfg(input int i, input logic [1:0] v, input logic al, input logic h,
                       input logic a, input logic ds, input logic [1:0] md, input logic [7:0] as);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ctx = 3'(i); cfg_vpe = v; cfg_alloc = al; cfg_halt = h;
        cfg_active = a; cfg_dslot = ds; cfg_mode = md; cfg_asid = as;
        @(negedge clk);
        cfg_we = 1'b0;
        m_vpe[i] = v; m_alloc[i] = al; m_halt[i] = h; m_act[i] = a;
        m_ds[i] = ds; m_mode[i] = md; m_asid[i] = as;
    endtask

    task automatic do_fork(input int src, input logic [31:0] pc, input logic [31:0] val,
                           input logic [4:0] dst, input bit disturb, input string tag);
        exp_t e;
        int found;
        found = -1;
        for (int i = 0; i < N; i++)
            if (found < 0 && m_vpe[i] == m_vpe[src] && m_alloc[i] && !m_halt[i] && !m_act[i])
                found = i;
        @(negedge clk);
        fork_req = 1'b1; fork_src = 3'(src); fork_pc = pc; fork_val = val; fork_dst = dst;
        e.ok  = (found >= 0);
        e.ctx = found;
        e.exc = (found >= 0) ? 0 : 1;
        e.due = cyc + 1 + ((found >= 0) ? found + 1 : N);
        e.val = val;
        e.dst = dst;
        sb_q.push_back(e);
        @(negedge clk);
        fork_req = 1'b0;
        if (disturb) begin
            // R9: a second request and a config write in mid-walk
            fork_req = 1'b1; fork_src = 3'(src); fork_pc = 32'hDEAD_0000; fork_val = 32'h1;
            cfg_we = 1'b1; cfg_ctx = 3'd1; cfg_vpe = 2'd0; cfg_alloc = 1'b1; cfg_halt = 1'b1;
            cfg_active = 1'b0; cfg_dslot = 1'b0; cfg_mode = 2'd0; cfg_asid = 8'h00;
            @(negedge clk);
            fork_req = 1'b0;
            cfg_we = 1'b0;
        end
        while (sb_q.size() != 0) @(negedge clk);
        if (found >= 0) begin
            m_act[found] = 1'b1; m_dirty[found] = 1'b1; m_ds[found] = 1'b0; m_run[found] = 2'd0;
            m_mode[found] = m_mode[src]; m_asid[found] = m_asid[src]; m_pc[found] = pc;
            check_ctx(found, tag);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vpe[i] = 2'd0; m_alloc[i] = 1'b1; m_halt[i] = 1'b0; m_act[i] = 1'b0;
            m_dirty[i] = 1'b0; m_ds[i] = 1'b0; m_run[i] = 2'd1; m_mode[i] = 2'd0;
            m_asid[i] = 8'd0; m_pc[i] = 32'd0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!fork_done && !thread_fault && !rf_we && exc_code == 3'd0, "R1", "idle outputs",
            {fork_done, thread_fault, rf_we, exc_code}, 0);
        for (int i = 0; i < N; i++) check_ctx(i, "R1");

        // R10: configure the requester
        cfg(0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 8'h5A);
        check_ctx(0, "R10");
        do_fork(0, 32'h0000_1000, 32'hCAFE_0001, 5'd4, 1'b0, "R5");

        // R3: exclude one context per condition
        cfg(2, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
        cfg(3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        cfg(4, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        cfg(5, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 8'h77);
        check_ctx(5, "R10");
        do_fork(0, 32'h0000_2000, 32'hCAFE_0002, 5'd9, 1'b0, "R3");
        do_fork(0, 32'h0000_3000, 32'hCAFE_0003, 5'd10, 1'b0, "R4");
        do_fork(0, 32'h0000_4000, 32'hCAFE_0004, 5'd31, 1'b0, "R4");

        // R7: nothing left
        do_fork(0, 32'h0000_5000, 32'hCAFE_0005, 5'd1, 1'b0, "R7");
        for (int i = 0; i < N; i++) check_ctx(i, "R7");

        // R8: free one again
        cfg(3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        do_fork(0, 32'h0000_6000, 32'hCAFE_0006, 5'd2, 1'b0, "R8");

        // R6: second virtual processor
        cfg(4, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 8'h33);
        do_fork(4, 32'h0000_7000, 32'hCAFE_0007, 5'd3, 1'b0, "R7");
        cfg(2, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        do_fork(4, 32'h0000_8000, 32'hCAFE_0008, 5'd5, 1'b0, "R6");

        // R9: disturbances during a long walk
        cfg(7, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        do_fork(0, 32'h0000_9000, 32'hCAFE_0009, 5'd6, 1'b1, "R9");
        repeat (12) @(negedge clk);
        check_ctx(1, "R9");
        check_ctx(7, "R9");
        chk(sb_q.size() == 0, "R9", "outstanding items", sb_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule